// File: doc/BRIEF.md
# Serial Control Bus Status Slave

This block sits as a slave on a three-wire synchronous serial control bus. The wires are serial data, a bus clock and a frame strobe. A rising strobe opens a frame. After that the master clocks the word one bit per bus clock period, bit 0 first. The slave samples each bit on the falling bus clock edge. It keeps the first six bits as an address field and uses that field to choose what to do for the rest of the frame.

Two outcomes are possible. In the first, the address selects status reporting. The slave then turns the bus around inside the frame: it stops capturing, loads a parallel status word and drives it back onto the bus one bit per rising bus clock edge. In the second, the address selects listening. The slave then latches a few chosen data bits as control levels for four downstream units.

All logic runs on a fast reference clock. The bus clock and strobe are sampled into that domain, and their edges act as enables. After the sixth address bit, a short sequencer issues store, decode, load and finish steps, one per reference clock cycle.

Top module: `scb_status_if`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, `ctrl_out` is all zero, `bus_doe` is low and `bus_dout` is low.
- R2: A rising edge on `bus_strobe` restarts the bit count at bit 0 and leaves transmit mode. `bus_doe` is then low for address bits 0 to 5 of the new frame.
- R3: Word bit k is the value on `bus_din` at the (k+1)-th falling `bus_clk` edge after the strobe. Address bit k is word bit k, for k = 0 to 5.
- R4: When address bits 3, 4 and 5 are all 1, `bus_doe` is high from the rising bus clock edge of word bit 6 until the next strobe.
- R5: The status word is 12 bits, sent most significant bit first. Bits 11:8 are `unit_local[3:0]` and bits 7:4 are `unit_tone[3:0]`. Bit 3 is `pwr_flag_a` and bit 2 is `temp_flag_a`. Bit 1 is the inverse of `pwr_flag_b` and bit 0 is the inverse of `temp_flag_b`. Status bit 11-j appears on `bus_dout` from the rising edge of word bit 6+j. After the 12 status bits, `bus_dout` carries 0.
- R6: When address bit 5 is 0, the falling edge of word bit 55 sets `ctrl_out[0]`, `[1]`, `[2]` and `[3]` to word bits 6, 7, 8 and 55.
- R7: When address bit 5 is 1, `ctrl_out` keeps its value through the frame. This holds both when the word selects status and when it selects neither mode.
- R8: After the sixth falling bus clock edge of a frame, the sequencer steps store, decode, load and finish on consecutive reference clock cycles, in that order. Status is ready on `bus_dout` before the rising edge of word bit 6.
- R9: `bus_doe` is high only while the current frame is in status mode. In a listen or unmatched frame it stays low for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk | input | 1 | Serial bus clock, asynchronous to clk |
| bus_strobe | input | 1 | Frame strobe; a rising edge starts a frame |
| bus_din | input | 1 | Serial data from the master |
| unit_local | input | 4 | Local-mode flags of the four units |
| unit_tone | input | 4 | Tone-detect flags of the four units |
| pwr_flag_a | input | 1 | Power flag, sent as is |
| temp_flag_a | input | 1 | Temperature flag, sent as is |
| pwr_flag_b | input | 1 | Power flag, sent inverted |
| temp_flag_b | input | 1 | Temperature flag, sent inverted |
| bus_dout | output | 1 | Serial status data toward the master |
| bus_doe | output | 1 | Output enable for bus_dout (high means driving) |
| ctrl_out | output | 4 | Latched control levels for the four units |

## Verification
The bench uses the default parameters: a 56-bit word, a 6-bit address and four units. It holds each bus clock phase for twelve reference cycles. With this word length the last control bit is taken on the final edge of the frame, so the commit can only happen at the frame's end. A 12-bit status reply ends at bit 17, and the bench checks 38 trailing zero bits after it. The twelve-cycle phase is long enough for synchronizer latency plus the four sequencer steps to fit before the first reply edge. The bench mixes random words from all three address classes with directed words. The directed words separate address bit order, mode decisions and the turnaround back to listening after a status frame.

// File: rtl/scb_pkg.sv
// Shared types for the serial control bus status slave.
package scb_pkg;

    // Steps of the post-address sequencer, in issue order.
    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_STORE  = 3'd1,
        SEQ_DECODE = 3'd2,
        SEQ_LOAD   = 3'd3,
        SEQ_FINISH = 3'd4
    } seq_step_e;

endpackage

// File: rtl/scb_edge_sync.sv
// Two-flop synchronizer with edge detection.
// Assumes: async_in stays stable for several clk periods between changes.
module scb_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Bring the input into the clk domain and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // One-cycle edge pulses from the synchronized level.
    always_comb begin
        level = sync_q;
        rise  = sync_q & ~prev_q;
        fall  = ~sync_q & prev_q;
    end

endmodule

// File: rtl/scb_step_seq.sv
// Post-address sequencer: once triggered it issues store, decode, load and
// finish, one per clk cycle. A new frame start returns it to idle.
// Assumes: the trigger comes at most once per frame.
module scb_step_seq
    import scb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_start,
    input  logic      trigger,
    output seq_step_e step,
    output logic      store_p,
    output logic      decode_p,
    output logic      load_p
);

    seq_step_e state_q;
    seq_step_e state_d;

    // Next-step selection: a fixed chain that starts from the trigger.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE:   if (trigger) state_d = SEQ_STORE;
            SEQ_STORE:  state_d = SEQ_DECODE;
            SEQ_DECODE: state_d = SEQ_LOAD;
            SEQ_LOAD:   state_d = SEQ_FINISH;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    // State register; a frame start aborts any step in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)           state_q <= SEQ_IDLE;
        else if (frame_start) state_q <= SEQ_IDLE;
        else                  state_q <= state_d;
    end

    // Step pulses decoded from the current state.
    always_comb begin
        step     = state_q;
        store_p  = (state_q == SEQ_STORE);
        decode_p = (state_q == SEQ_DECODE);
        load_p   = (state_q == SEQ_LOAD);
    end

endmodule

// File: rtl/scb_word_path.sv
// Word datapath: bit counter, one shift register shared by capture and
// reply, the address register, the status-mode flag and the listen-mode
// control latches.
// Assumes: ADDR_BITS >= 6, N_UNITS >= 2, and WORD_BITS > ADDR_BITS + N_UNITS.
module scb_word_path #(
    parameter int WORD_BITS = 56,
    parameter int ADDR_BITS = 6,
    parameter int N_UNITS   = 4,
    parameter int STAT_W    = 2 * N_UNITS + 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 fall_evt,
    input  logic                 rise_evt,
    input  logic                 din,
    input  logic                 store_p,
    input  logic                 decode_p,
    input  logic                 load_p,
    input  logic [STAT_W-1:0]    stat_word,
    output logic                 six_hit,
    output logic [ADDR_BITS-1:0] addr_q,
    output logic                 stat_flag,
    output logic                 dout,
    output logic                 doe,
    output logic [N_UNITS-1:0]   ctrl_out
);

    localparam int SR_W  = (STAT_W > ADDR_BITS) ? STAT_W : ADDR_BITS;
    localparam int CNT_W = $clog2(WORD_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);
    localparam logic [CNT_W-1:0] IDX_ADDR = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] IDX_LAST = CNT_W'(WORD_BITS - 1);

    logic [CNT_W-1:0]   cnt_q;
    logic [SR_W-1:0]    sr_q;
    logic               tx_on_q;
    logic               dout_q;
    logic [N_UNITS-2:0] pend_q;
    logic [N_UNITS-1:0] ctrl_q;
    logic               status_hit;
    logic               commit;

    // Mode decode from the stored address and the end-of-word commit.
    always_comb begin
        status_hit = addr_q[3] & addr_q[4] & addr_q[5];
        six_hit    = fall_evt && (cnt_q == IDX_ADDR);
        commit     = fall_evt && (cnt_q == IDX_LAST) && !stat_flag && !addr_q[5];
    end

    // Bit counter: counts falling bus clock edges since the strobe, then saturates.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (frame_start)                 cnt_q <= '0;
        else if (fall_evt && cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
    end

    // Shared shift register: capture, clear on status decode, load, then reply.
    always_ff @(posedge clk) begin
        if (!rst_n)                       sr_q <= '0;
        else if (frame_start)             sr_q <= '0;
        else if (decode_p && status_hit)  sr_q <= '0;
        else if (load_p && stat_flag)     sr_q <= SR_W'(stat_word);
        else if (rise_evt && tx_on_q)     sr_q <= sr_q << 1;
        else if (fall_evt && !stat_flag)  sr_q <= {sr_q[SR_W-2:0], din};
    end

    // Address store: the oldest captured bit becomes address bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (store_p) begin
            for (int k = 0; k < ADDR_BITS; k++) begin
                addr_q[k] <= sr_q[ADDR_BITS-1-k];
            end
        end
    end

    // Status-mode flag: cleared by the strobe, set by the decode step.
    always_ff @(posedge clk) begin
        if (!rst_n)           stat_flag <= 1'b0;
        else if (frame_start) stat_flag <= 1'b0;
        else if (decode_p)    stat_flag <= status_hit;
    end

    // Transmit enable: on after the status load, off at the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                   tx_on_q <= 1'b0;
        else if (frame_start)         tx_on_q <= 1'b0;
        else if (load_p && stat_flag) tx_on_q <= 1'b1;
    end

    // Serial output register: presents the next status bit on each rising bus edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                   dout_q <= 1'b0;
        else if (frame_start)         dout_q <= 1'b0;
        else if (rise_evt && tx_on_q) dout_q <= sr_q[STAT_W-1];
    end

    // Pending control bits taken straight after the address field.
    for (genvar g = 0; g < N_UNITS - 1; g++) begin : g_pend
        localparam logic [CNT_W-1:0] POS = CNT_W'(ADDR_BITS + g);
        // Hold word bit ADDR_BITS+g until the end of the word.
        always_ff @(posedge clk) begin
            if (!rst_n)                        pend_q[g] <= 1'b0;
            else if (frame_start)              pend_q[g] <= 1'b0;
            else if (fall_evt && cnt_q == POS) pend_q[g] <= din;
        end
    end

    // Control latches: updated only by a listen-mode word at its last bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (commit) ctrl_q <= {din, pend_q};
    end

    // Output mapping.
    always_comb begin
        dout     = dout_q;
        doe      = tx_on_q;
        ctrl_out = ctrl_q;
    end

endmodule

// File: rtl/scb_status_if.sv
// Serial control bus status slave, top level. It synchronizes the bus clock,
// strobe and data into the reference clock domain. It runs the
// post-address sequencer and the word datapath, and assembles the parallel
// status word.
// Assumes: every bus clock phase lasts at least 8 clk cycles.
module scb_status_if
    import scb_pkg::*;
#(
    parameter int WORD_BITS = 56,
    parameter int ADDR_BITS = 6,
    parameter int N_UNITS   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_clk,
    input  logic               bus_strobe,
    input  logic               bus_din,
    input  logic [N_UNITS-1:0] unit_local,
    input  logic [N_UNITS-1:0] unit_tone,
    input  logic               pwr_flag_a,
    input  logic               temp_flag_a,
    input  logic               pwr_flag_b,
    input  logic               temp_flag_b,
    output logic               bus_dout,
    output logic               bus_doe,
    output logic [N_UNITS-1:0] ctrl_out
);

    localparam int STAT_W = 2 * N_UNITS + 4;

    logic                 clk_lvl, clk_rise, clk_fall;
    logic                 stb_lvl, strobe_rise, stb_fall;
    logic                 din_lvl, din_rise, din_fall;
    logic                 six_hit, store_p, decode_p, load_p, stat_flag;
    logic [ADDR_BITS-1:0] addr_q;
    logic [STAT_W-1:0]    stat_word;
    seq_step_e            seq_step;

    scb_edge_sync u_sync_clk (
        .clk(clk), .rst_n(rst_n), .async_in(bus_clk),
        .level(clk_lvl), .rise(clk_rise), .fall(clk_fall)
    );

    scb_edge_sync u_sync_stb (
        .clk(clk), .rst_n(rst_n), .async_in(bus_strobe),
        .level(stb_lvl), .rise(strobe_rise), .fall(stb_fall)
    );

    scb_edge_sync u_sync_din (
        .clk(clk), .rst_n(rst_n), .async_in(bus_din),
        .level(din_lvl), .rise(din_rise), .fall(din_fall)
    );

    // Status word, MSB first: local, tone, A flags true, B flags inverted.
    always_comb begin
        stat_word = {unit_local, unit_tone, pwr_flag_a, temp_flag_a,
                     ~pwr_flag_b, ~temp_flag_b};
    end

    scb_step_seq u_seq (
        .clk(clk), .rst_n(rst_n), .frame_start(strobe_rise), .trigger(six_hit),
        .step(seq_step), .store_p(store_p), .decode_p(decode_p), .load_p(load_p)
    );

    scb_word_path #(
        .WORD_BITS(WORD_BITS), .ADDR_BITS(ADDR_BITS),
        .N_UNITS(N_UNITS), .STAT_W(STAT_W)
    ) u_path (
        .clk(clk), .rst_n(rst_n), .frame_start(strobe_rise),
        .fall_evt(clk_fall), .rise_evt(clk_rise), .din(din_lvl),
        .store_p(store_p), .decode_p(decode_p), .load_p(load_p),
        .stat_word(stat_word), .six_hit(six_hit), .addr_q(addr_q),
        .stat_flag(stat_flag), .dout(bus_dout), .doe(bus_doe),
        .ctrl_out(ctrl_out)
    );

endmodule

// File: rtl/scb_status_if_chk.sv
// Property checker for scb_status_if, attached with bind below.
// Assumes: internal names as declared in the top module.
module scb_status_if_chk
    import scb_pkg::*;
#(
    parameter int N_UNITS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input seq_step_e          step,
    input logic               frame_start,
    input logic               six_hit,
    input logic               stat_flag,
    input logic               bus_doe,
    input logic [N_UNITS-1:0] ctrl_out,
    input logic               addr5
);

    // R8
    store_after_six_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == SEQ_STORE) |-> $past(six_hit));

    // R8
    decode_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == SEQ_STORE && !frame_start) |=> (step == SEQ_DECODE));

    // R8
    load_after_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == SEQ_DECODE && !frame_start) |=> (step == SEQ_LOAD));

    // R9
    doe_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> stat_flag);

    // R2
    strobe_drops_doe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !bus_doe);

    // R7
    ctrl_only_on_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_out != $past(ctrl_out)) |-> (!$past(addr5) && !$past(stat_flag)));

endmodule

bind scb_status_if scb_status_if_chk #(.N_UNITS(N_UNITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .step(seq_step), .frame_start(strobe_rise),
    .six_hit(six_hit), .stat_flag(stat_flag), .bus_doe(bus_doe),
    .ctrl_out(ctrl_out), .addr5(addr_q[5])
);

// File: tb/tb_scb_status_if.sv
module tb_scb_status_if;

    localparam int WB = 56;
    localparam int NU = 4;
    localparam int HP = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_clk, bus_strobe, bus_din;
    logic [NU-1:0] unit_local, unit_tone;
    logic          pwr_flag_a, temp_flag_a, pwr_flag_b, temp_flag_b;
    logic          bus_dout, bus_doe;
    logic [NU-1:0] ctrl_out;

    int            n_vec = 0;
    int            n_bad = 0;
    logic [NU-1:0] ctrl_exp;

    always #5 clk = ~clk;

    scb_status_if dut (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_strobe(bus_strobe),
        .bus_din(bus_din), .unit_local(unit_local), .unit_tone(unit_tone),
        .pwr_flag_a(pwr_flag_a), .temp_flag_a(temp_flag_a),
        .pwr_flag_b(pwr_flag_b), .temp_flag_b(temp_flag_b),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .ctrl_out(ctrl_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected status word per R5.
    function automatic logic [11:0] exp_status();
        return {unit_local, unit_tone, pwr_flag_a, temp_flag_a, ~pwr_flag_b, ~temp_flag_b};
    endfunction

    // Expected control latches per R6 and R7.
    function automatic logic [NU-1:0] exp_ctrl(input logic [WB-1:0] w, input logic [NU-1:0] prev);
        return w[5] ? prev : {w[55], w[8], w[7], w[6]};
    endfunction

    task automatic run_frame(input logic [WB-1:0] w);
        logic [11:0] st;
        logic        smode;
        st    = exp_status();
        smode = w[3] & w[4] & w[5];
        bus_strobe = 1'b1;
        wait_clk(HP);
        bus_strobe = 1'b0;
        wait_clk(HP);
        for (int i = 0; i < WB; i++) begin
            bus_din = w[i];
            bus_clk = 1'b1;
            wait_clk(HP);
            if (i < 6) begin
                chk("R2 doe low during address", bus_doe, 0);
            end else if (smode) begin
                chk("R4 doe in status frame", bus_doe, 1);
                if (i == 6)       chk("R8 first status bit ready", bus_dout, st[11]);
                else if (i <= 17) chk("R5 status bit", bus_dout, st[17-i]);
                else              chk("R5 trailing zero", bus_dout, 0);
            end else begin
                chk("R9 doe low outside status", bus_doe, 0);
            end
            bus_clk = 1'b0;
            wait_clk(HP);
        end
        wait_clk(4);
        ctrl_exp = exp_ctrl(w, ctrl_exp);
        if (w[5]) chk("R7 ctrl unchanged", ctrl_out, ctrl_exp);
        else      chk("R6 ctrl latched", ctrl_out, ctrl_exp);
    endtask

    task automatic set_status(input logic [11:0] s);
        {unit_local, unit_tone, pwr_flag_a, temp_flag_a, pwr_flag_b, temp_flag_b} = s;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait_clk(190000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [WB-1:0] w;
        int            cls;
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        bus_clk = 1'b0; bus_strobe = 1'b0; bus_din = 1'b0;
        set_status(12'h000);
        ctrl_exp = '0;
        wait_clk(5);
        chk("R1 ctrl reset", ctrl_out, 0);
        chk("R1 doe reset", bus_doe, 0);
        chk("R1 dout reset", bus_dout, 0);
        rst_n = 1'b1;
        wait_clk(1);
        chk("R1 ctrl after release", ctrl_out, 0);

        // R6: listen word with distinct control bits.
        w = '0; w[6] = 1'b1; w[8] = 1'b1; w[55] = 1'b1;
        run_frame(w);
        // R3: low address bits set, bit 5 clear -> listen, not status.
        w = '0; w[2:0] = 3'b111; w[7] = 1'b1;
        run_frame(w);
        // R4/R5: status word with an asymmetric pattern.
        set_status(12'b1010_0110_1001);
        w = '0; w[5:3] = 3'b111; w[6] = 1'b1; w[55] = 1'b1;
        run_frame(w);
        // R7: unmatched address (bit 5 high, bit 3 low).
        w = '1; w[3] = 1'b0;
        run_frame(w);
        // R2: listen right after a status frame.
        set_status(12'b0101_1001_0110);
        w = '0; w[5:3] = 3'b111;
        run_frame(w);
        w = '0; w[7] = 1'b1; w[55] = 1'b1;
        run_frame(w);

        // Random frames across the three address classes.
        for (int n = 0; n < 36; n++) begin
            w = {$urandom, $urandom};
            cls = int'($urandom % 3);
            if (cls == 0)      w[5] = 1'b0;
            else if (cls == 1) w[5:3] = 3'b111;
            else begin
                w[5] = 1'b1;
                if (w[4:3] == 2'b11) w[3] = 1'b0;
            end
            set_status(12'($urandom));
            run_frame(w);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule